// File: doc/BRIEF.md
# Per-Core Banked Timer Router

This block puts one private countdown timer beside each core and reaches all of them through a single register bus. The address space is cut into windows of 0x20 bytes each. Window 0 is an alias: the timer it reaches is chosen by the core-ID sideband that travels with the access, so every core finds its own timer at the same address. Window k+1 always reaches the timer of core k, whichever core issues the access. This lets any core inspect or program another core's timer.

The router checks every access before it is steered. These accesses get an error response, return zero and change nothing:
- a transfer that is not a whole aligned 32-bit word;
- a window past the last core;
- an alias access carrying a core ID the block does not have.

Exactly one access is taken per cycle, and its response comes back on the following cycle. Each timer drives its own interrupt line, and bit k of the interrupt bus belongs to core k. The core count is a parameter. A value outside 1 to `MAX_CORES` stops elaboration.

Top module: `core_timer_router`

## Requirements
- R1: An access to window w, where w = req_addr[ADDR_W-1:5] and 1 ≤ w ≤ NUM_CORES, reaches the timer of core w-1 whatever req_core_id carries.
- R2: An access to window 0 reaches the timer of core req_core_id when req_core_id < NUM_CORES.
- R3: A window-0 access with req_core_id ≥ NUM_CORES is an error.
- R4: An access to a window w > NUM_CORES is an error.
- R5: An access with req_size other than 2 (word; 0 is byte, 1 is halfword), or with req_addr[1:0] nonzero, is an error.
- R6: An erroring access returns rsp_err = 1 and rsp_rdata = 0, and it writes nothing into any timer.
- R7: Every cycle with req_valid high is followed, one cycle later, by exactly one cycle with rsp_valid high. Without a request there is no response. A write that succeeds returns rsp_err = 0 and rsp_rdata = 0.
- R8: The offset inside a window, req_addr[4:2], selects one of these timer registers:
  - 0: reload value. A write here also sets the count.
  - 1: current count.
  - 2: control. Bit 0 enables the timer, bit 1 selects auto-reload, bit 2 enables the interrupt, and bits 15:8 hold the prescale.
  - 3: status. Bit 0 is the expiry flag, and writing 1 to it clears it.
  - 4 to 7: read as zero, and writes there are ignored.
- R9: An enabled timer with a nonzero count decrements once every prescale+1 cycles. When a count of 1 expires, the status flag is set. irq[k] is high while core k's status flag and interrupt enable are both set.
- R10: After reset every timer register reads zero, all irq lines are low and rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address: window in bits ADDR_W-1:5, register in bits 4:2 |
| req_size | input | 2 | Transfer size: 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Write data |
| req_core_id | input | CID_W | ID of the requesting core |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | 32 | Read data, zero on error or write |
| irq | output | NUM_CORES | Timer interrupt, bit k for core k |

## Verification
The assertions assume that req_core_id is stable and meaningful only while req_valid is high, and that no access is held off, since the router takes one every cycle. The assertions on steering also assume that the window field and the size field are sampled in the same cycle as req_valid. The random stimulus draws core IDs from just above the valid range and windows from one past the last core. Sizes and misalignment are drawn rarely, so most accesses are legal. Random control writes always clear the enable bit, which keeps every count static and lets the bench model predict each read exactly. Expiry is exercised only in a directed case where the countdown length is known.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  localparam int unsigned WIN_SHIFT = 5;
  localparam logic [1:0]  SZ_WORD   = 2'd2;
  localparam logic [2:0]  OFF_LOAD  = 3'd0;
  localparam logic [2:0]  OFF_COUNT = 3'd1;
  localparam logic [2:0]  OFF_CTRL  = 3'd2;
  localparam logic [2:0]  OFF_STAT  = 3'd3;

  // window number of a byte address
  function automatic int unsigned win_of(input logic [15:0] a);
    return int'(a >> WIN_SHIFT);
  endfunction

  // register slot inside a window
  function automatic logic [2:0] off_of(input logic [15:0] a);
    return a[4:2];
  endfunction

  // timer addressed by a legal access
  function automatic int unsigned target_of(input int unsigned win,
                                            input int unsigned cid);
    return (win == 0) ? cid : win - 1;
  endfunction
endpackage

// File: rtl/ctr_decode.sv
module ctr_decode #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 9,
  parameter int CID_W     = 3
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [CID_W-1:0]  cid,
  output logic [NUM_CORES-1:0] sel,
  output logic              err,
  output logic [2:0]        off
);
  import ctr_pkg::*;

  int unsigned win;
  int unsigned tgt;
  logic        bad_fmt, bad_win, bad_cid;

  always_comb begin
    win     = win_of(16'(addr));
    off     = off_of(16'(addr));
    bad_fmt = (size != SZ_WORD) || (addr[1:0] != 2'b00);
    bad_win = win > NUM_CORES;
    bad_cid = (win == 0) && (int'(cid) >= NUM_CORES);
    err     = valid && (bad_fmt || bad_win || bad_cid);
    tgt     = target_of(win, int'(cid));
    for (int k = 0; k < NUM_CORES; k++) begin
      sel[k] = valid && !err && (tgt == k);
    end
  end
endmodule

// File: rtl/ctr_timer.sv
module ctr_timer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel,
  input  logic        wr,
  input  logic [2:0]  off,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  import ctr_pkg::*;

  logic [31:0] load_q, count_q, ctrl_q;
  logic [7:0]  pre_q;
  logic        stat_q;
  logic        running, tick, expire;

  assign running = ctrl_q[0] && (count_q != 32'd0);
  assign tick    = running && (pre_q == ctrl_q[15:8]);
  assign expire  = tick && (count_q == 32'd1);
  assign irq     = stat_q && ctrl_q[2];

  always_comb begin
    unique case (off)
      OFF_LOAD:  rdata = load_q;
      OFF_COUNT: rdata = count_q;
      OFF_CTRL:  rdata = ctrl_q;
      OFF_STAT:  rdata = {31'd0, stat_q};
      default:   rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q  <= '0;
      count_q <= '0;
      ctrl_q  <= '0;
      pre_q   <= '0;
      stat_q  <= 1'b0;
    end else begin
      if (running) begin
        if (tick) begin
          pre_q <= '0;
          if (expire) begin
            stat_q  <= 1'b1;
            count_q <= ctrl_q[1] ? load_q : 32'd0;
          end else begin
            count_q <= count_q - 32'd1;
          end
        end else begin
          pre_q <= pre_q + 8'd1;
        end
      end
      if (sel && wr) begin
        unique case (off)
          OFF_LOAD: begin
            load_q  <= wdata;
            count_q <= wdata;
            pre_q   <= '0;
          end
          OFF_COUNT: begin
            count_q <= wdata;
            pre_q   <= '0;
          end
          OFF_CTRL: begin
            ctrl_q <= wdata;
            pre_q  <= '0;
            if (wdata[0] && !running && wdata[1]) count_q <= load_q;
          end
          OFF_STAT: if (wdata[0]) stat_q <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  // R8: the flag only drops on a write of 1 to the status slot
  assert_stat_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_q) |-> $past(sel && wr && off == OFF_STAT && wdata[0]));

  // R9: the flag is only raised by an enabled countdown
  assert_stat_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q) |-> $past(ctrl_q[0]));
endmodule

// File: rtl/core_timer_router.sv
module core_timer_router #(
  parameter int NUM_CORES = 4,
  parameter int MAX_CORES = 8,
  parameter int ADDR_W    = $clog2(MAX_CORES + 1) + 5,
  parameter int CID_W     = $clog2(MAX_CORES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [1:0]           req_size,
  input  logic [31:0]          req_wdata,
  input  logic [CID_W-1:0]     req_core_id,
  output logic                 rsp_valid,
  output logic                 rsp_err,
  output logic [31:0]          rsp_rdata,
  output logic [NUM_CORES-1:0] irq
);
  import ctr_pkg::*;

  if (NUM_CORES < 1 || NUM_CORES > MAX_CORES) begin : g_bad_count
    $error("core_timer_router: NUM_CORES out of range 1..MAX_CORES");
  end

  logic [NUM_CORES-1:0]       tmr_sel;
  logic                       dec_err;
  logic [2:0]                 dec_off;
  logic [NUM_CORES-1:0][31:0] tmr_rdata;
  logic [31:0]                rd_mux;

  ctr_decode #(
    .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .CID_W(CID_W)
  ) decode_i (
    .valid(req_valid), .addr(req_addr), .size(req_size),
    .cid(req_core_id), .sel(tmr_sel), .err(dec_err), .off(dec_off)
  );

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_timer
    ctr_timer timer_i (
      .clk(clk), .rst_n(rst_n), .sel(tmr_sel[k]), .wr(req_write),
      .off(dec_off), .wdata(req_wdata), .rdata(tmr_rdata[k]), .irq(irq[k])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_CORES; k++) begin
      if (tmr_sel[k]) rd_mux = rd_mux | tmr_rdata[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && dec_err;
      rsp_rdata <= (req_valid && !dec_err && !req_write) ? rd_mux : 32'd0;
    end
  end

  // R1: at most one timer is touched per access
  assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tmr_sel));

  // R6: an erroring access reaches no timer
  assert_err_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && dec_err) |-> (tmr_sel == '0));

  // R2: a legal alias access lands on the requester's own timer
  assert_alias_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[ADDR_W-1:5] == '0 && req_size == SZ_WORD &&
     req_addr[1:0] == 2'b00 && int'(req_core_id) < NUM_CORES)
    |-> (tmr_sel == (NUM_CORES'(1) << req_core_id)));

  // R7: one response per request, one cycle later
  assert_rsp_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_rsp_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
endmodule

// File: tb/core_timer_router_tb.sv
`timescale 1ns/1ps
module core_timer_router_tb_top;
  localparam int N      = 4;
  localparam int ADDR_W = 9;
  localparam int CID_W  = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [1:0]        req_size;
  logic [31:0]       req_wdata;
  logic [CID_W-1:0]  req_core_id;
  logic              rsp_valid, rsp_err;
  logic [31:0]       rsp_rdata;
  logic [N-1:0]      irq;

  int unsigned n_chk = 0, n_bad = 0;
  bit          done  = 1'b0;
  logic [31:0] m_load [N];
  logic [31:0] m_cnt  [N];
  logic [31:0] m_ctrl [N];

  always #2.5 clk = ~clk;

  core_timer_router #(.NUM_CORES(N), .MAX_CORES(8), .ADDR_W(ADDR_W), .CID_W(CID_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .req_core_id(req_core_id), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // error rule restated from R3, R4, R5
  function automatic bit exp_err(input int unsigned addr, input logic [1:0] sz,
                                 input int unsigned cid);
    int unsigned w = addr / 32;
    return (sz != 2'd2) || (addr % 4 != 0) || (w > N) || (w == 0 && cid >= N);
  endfunction

  function automatic int unsigned exp_core(input int unsigned addr, input int unsigned cid);
    return (addr / 32 == 0) ? cid : addr / 32 - 1;
  endfunction

  function automatic logic [31:0] exp_read(input int unsigned c, input int unsigned slot);
    case (slot)
      0: return m_load[c];
      1: return m_cnt[c];
      2: return m_ctrl[c];
      default: return 32'd0;
    endcase
  endfunction

  task automatic access(input logic wr, input int unsigned addr, input logic [31:0] wd,
                        input logic [1:0] sz, input int unsigned cid,
                        output logic [31:0] rd, output logic er);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = ADDR_W'(addr);
    req_wdata = wd; req_size = sz; req_core_id = CID_W'(cid);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid === 1'b1, "R7 response after request", 32'(rsp_valid), 32'd1);
    rd = rsp_rdata; er = rsp_err;
    @(negedge clk);
    check(rsp_valid === 1'b0, "R7 no response when idle", 32'(rsp_valid), 32'd0);
  endtask

  // one access, checked against the model, model updated on success
  task automatic do_checked(input logic wr, input int unsigned addr, input logic [31:0] wd,
                            input logic [1:0] sz, input int unsigned cid);
    logic [31:0] rd; logic er; bit e; int unsigned c, slot;
    e = exp_err(addr, sz, cid);
    access(wr, addr, wd, sz, cid, rd, er);
    check(er === e, e ? "R3/R4/R5 error flagged" : "R1/R2 legal access", 32'(er), 32'(e));
    if (e) begin
      check(rd === 32'd0, "R6 error data zero", rd, 32'd0);
    end else begin
      c = exp_core(addr, cid); slot = (addr % 32) / 4;
      if (wr) begin
        check(rd === 32'd0, "R7 write data zero", rd, 32'd0);
        case (slot)
          0: begin m_load[c] = wd; m_cnt[c] = wd; end
          1: m_cnt[c] = wd;
          2: m_ctrl[c] = wd;
          default: ;
        endcase
      end else begin
        check(rd === exp_read(c, slot), "R8 register read", rd, exp_read(c, slot));
      end
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      summary();
    end
  end

  initial begin
    logic [31:0] rd; logic er;
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_size = 2'd2; req_wdata = '0; req_core_id = '0;
    for (int k = 0; k < N; k++) begin m_load[k] = 0; m_cnt[k] = 0; m_ctrl[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state
    check(rsp_valid === 1'b0, "R10 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    check(irq === '0, "R10 irq after reset", 32'(irq), 32'd0);
    for (int k = 0; k < N; k++) do_checked(1'b0, (k + 1) * 32, 0, 2'd2, 0);

    // R2 then R1: alias write from core 2, direct read through window 3
    do_checked(1'b1, 32'h00, 32'hA5A5_0000, 2'd2, 2);
    do_checked(1'b0, 3 * 32 + 0, 0, 2'd2, 0);
    do_checked(1'b0, 3 * 32 + 4, 0, 2'd2, 1);
    check(m_load[2] === 32'hA5A5_0000, "R2 alias reached core 2", m_load[2], 32'hA5A5_0000);

    // R3 and R6: bad core ID writes nothing anywhere
    do_checked(1'b1, 32'h00, 32'hDEAD_BEEF, 2'd2, N);
    do_checked(1'b1, 32'h00, 32'hDEAD_BEEF, 2'd2, 7);
    for (int k = 0; k < N; k++) do_checked(1'b0, (k + 1) * 32, 0, 2'd2, 0);

    // R4: window past the last core
    do_checked(1'b1, (N + 1) * 32, 32'h1111_2222, 2'd2, 0);
    do_checked(1'b0, (N + 2) * 32 + 8, 0, 2'd2, 1);

    // R5: byte, halfword, misaligned
    do_checked(1'b1, 1 * 32, 32'h3333_4444, 2'd0, 0);
    do_checked(1'b1, 2 * 32, 32'h3333_4444, 2'd1, 0);
    do_checked(1'b1, 1 * 32 + 2, 32'h3333_4444, 2'd2, 0);
    do_checked(1'b0, 1 * 32, 0, 2'd2, 0);

    // random mix, enable bit always cleared so counts stay still
    for (int i = 0; i < 800; i++) begin
      int unsigned w, slot, addr, cid; logic [1:0] sz; logic [31:0] wd;
      w    = $urandom % (N + 2);
      slot = $urandom % 6;
      addr = w * 32 + slot * 4;
      if ($urandom % 12 == 0) addr = addr + 1 + $urandom % 3;
      sz   = ($urandom % 10 == 0) ? 2'($urandom % 4) : 2'd2;
      cid  = $urandom % (N + 2);
      wd   = $urandom;
      if (slot == 2) wd[0] = 1'b0;
      do_checked(1'($urandom % 2), addr, wd, sz, cid);
    end

    // R9: core 1 counts 3 down with prescale 0
    do_checked(1'b1, 2 * 32 + 8, 32'd0, 2'd2, 0);
    do_checked(1'b1, 2 * 32 + 0, 32'd3, 2'd2, 0);
    access(1'b1, 2 * 32 + 8, 32'h0000_0005, 2'd2, 0, rd, er);
    m_ctrl[1] = 32'h5; m_cnt[1] = 0;
    repeat (8) @(negedge clk);
    check(irq === 4'b0010, "R9 irq of core 1 only", 32'(irq), 32'h2);
    access(1'b0, 32'h0C, 0, 2'd2, 1, rd, er);
    check(rd === 32'd1, "R9 status via alias", rd, 32'd1);
    do_checked(1'b0, 2 * 32 + 4, 0, 2'd2, 3);
    do_checked(1'b1, 2 * 32 + 12, 32'd1, 2'd2, 0);
    @(negedge clk);
    check(irq === 4'b0000, "R8 status cleared drops irq", 32'(irq), 32'h0);

    // R10: reset mid-run
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < N; k++) begin m_load[k] = 0; m_cnt[k] = 0; m_ctrl[k] = 0; end
    check(irq === '0, "R10 irq after second reset", 32'(irq), 32'd0);
    do_checked(1'b0, 2 * 32 + 0, 0, 2'd2, 0);
    do_checked(1'b0, 2 * 32 + 8, 0, 2'd2, 0);
    do_checked(1'b0, 3 * 32 + 0, 0, 2'd2, 0);

    done = 1'b1;
    summary();
  end
endmodule